// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches the bus cycles of a processor and raises a one-cycle break request when a cycle matches a programmed condition. There are two channels, A and B. Each channel compares the cycle address with a reference address under a mask, and can optionally require an address-space identifier to match. It also filters on cycle attributes: fetch or data access, read or write, word or longword size, and, for instruction fetches, whether the cycle is reported before or after the instruction executes. Channel B can also compare the data bus under a data mask and can hold back its break until the Nth qualifying match.

The channels either act independently or are chained, so that channel A must match before channel B can fire. Software programs the block through a flat register port. Each register write takes effect at the clock edge. Reads are combinational. A bus cycle presented with `cyc_valid` high at a clock edge produces `brk_req` and `brk_src` in the cycle after that edge.

Top module: `bus_break_unit`

## Requirements
- R1: A channel compares the address under its mask register, where a mask bit of 1 makes that address bit don't-care. A mask of zero requires every address bit to be equal.
- R2: Condition register bits [10:9] select the access type (01 fetch, 10 data), bits [12:11] select the direction (01 read, 10 write) and bits [14:13] select the size (01 word, 10 longword). A value of 00 or 11 accepts either. A fetch is always treated as a read, whatever `cyc_write` carries, so a write-only channel never matches a fetch.
- R3: For fetch cycles, condition bit 15 picks the timing: 0 matches only cycles with `cyc_after`=0 (before execution) and 1 matches only `cyc_after`=1. Data cycles ignore `cyc_after`.
- R4: When condition bit 8 is set, the channel also requires `cyc_asid` to equal condition bits [7:0]. When bit 8 is clear, the identifier is ignored.
- R5: When CTRL bit 4 is set, channel B also requires `cyc_data` to equal the DATA_B register in every bit where DMASK_B is 0. When bit 4 is clear, the data bus is ignored.
- R6: In independent mode (CTRL bit 2 = 0), a match on channel A sets `brk_src[0]` and a match on channel B sets `brk_src[1]`, together with `brk_req`, for exactly the one cycle after the matching edge.
- R7: In sequential mode (CTRL bit 2 = 1), channel A never fires by itself. A channel A match arms the sequence, and only a later channel B match while armed fires `brk_src[1]`. The armed state clears when that break fires and on any CTRL write, and a B match in the same cycle as the arming A match does not fire.
- R8: With CTRL bit 3 set, each qualifying channel B match decrements the COUNT register down to 0. A match fires only when COUNT reads 1 or 0, so a count of 5 absorbs four matches and fires on the fifth. A write to COUNT reloads it, and a read returns the remaining count.
- R9: CTRL bits 8 (A) and 9 (B) are sticky match flags, set whenever the channel's condition matches. Writing 0 to a flag clears it and writing 1 leaves it unchanged. A match in the same cycle wins over the clear.
- R10: After reset every register reads 0, `brk_req` and `brk_src` are 0, and both channels are disabled (CTRL bit 0 enables A, bit 1 enables B), so no cycle matches.
- R11: The registers read back what was written: index 0 ADDR_A, 1 MASK_A, 2 COND_A, 3 ADDR_B, 4 MASK_B, 5 COND_B, 6 DATA_B, 7 DMASK_B, 8 CTRL, 9 COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_addr | input | ADDR_W | Cycle address |
| cyc_asid | input | ASID_W | Cycle address-space identifier |
| cyc_data | input | DATA_W | Cycle data |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write (ignored on fetch) |
| cyc_long | input | 1 | 1 = longword, 0 = word |
| cyc_after | input | 1 | Fetch reported after execution (1) or before (0) |
| brk_req | output | 1 | Break request pulse |
| brk_src | output | 2 | Channel that fired: bit 0 A, bit 1 B |

## Verification
Address matching is tried with an exact hit, a single-bit miss, and a hit and a miss inside and outside a masked low nibble. These separate an exact compare from a masked one. Attribute tests present a fetch that claims to be a write, and data cycles that differ only in size or direction, so each filter is shown to act alone. Identifier and data tests pair a matching value with a mismatching one, with the optional compare enabled and then disabled. The sequence tests run B alone, A alone, A then B, a repeated B, and A followed by a CTRL write, which separates arming, firing and disarming. The count test runs six matches against a count of 5 and reads the remaining count on the way.

// File: rtl/bbrk_pkg.sv
package bbrk_pkg;

  // Two-bit attribute selector: one value per polarity, the rest accept both
  typedef enum logic [1:0] {
    SEL_ANY  = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_BOTH = 2'b11
  } sel_e;

  // Register indices
  localparam logic [3:0] IDX_ADDR_A  = 4'd0;
  localparam logic [3:0] IDX_MASK_A  = 4'd1;
  localparam logic [3:0] IDX_COND_A  = 4'd2;
  localparam logic [3:0] IDX_ADDR_B  = 4'd3;
  localparam logic [3:0] IDX_MASK_B  = 4'd4;
  localparam logic [3:0] IDX_COND_B  = 4'd5;
  localparam logic [3:0] IDX_DATA_B  = 4'd6;
  localparam logic [3:0] IDX_DMASK_B = 4'd7;
  localparam logic [3:0] IDX_CTRL    = 4'd8;
  localparam logic [3:0] IDX_COUNT   = 4'd9;

  // Condition register field positions
  localparam int C_ASID_EN = 8;
  localparam int C_TYPE_LO = 9;
  localparam int C_DIR_LO  = 11;
  localparam int C_SIZE_LO = 13;
  localparam int C_AFTER   = 15;
  localparam int COND_W    = 16;

  // Control register bit positions
  localparam int K_EN_A   = 0;
  localparam int K_EN_B   = 1;
  localparam int K_SEQ    = 2;
  localparam int K_CNT    = 3;
  localparam int K_DATA   = 4;
  localparam int K_FLAG_A = 8;
  localparam int K_FLAG_B = 9;

  // Attribute filter: LOW accepts a 0 attribute, HIGH accepts a 1
  function automatic logic sel_ok(input logic [1:0] sel, input logic attr);
    case (sel_e'(sel))
      SEL_LOW:  sel_ok = ~attr;
      SEL_HIGH: sel_ok = attr;
      default:  sel_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bbrk_chan.sv
module bbrk_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [ADDR_W-1:0]         ref_addr,
  input  logic [ADDR_W-1:0]         addr_mask,
  input  logic [bbrk_pkg::COND_W-1:0] cond,
  input  logic                      data_en,
  input  logic [DATA_W-1:0]         ref_data,
  input  logic [DATA_W-1:0]         data_mask,
  input  logic                      cyc_valid,
  input  logic [ADDR_W-1:0]         cyc_addr,
  input  logic [ASID_W-1:0]         cyc_asid,
  input  logic [DATA_W-1:0]         cyc_data,
  input  logic                      cyc_fetch,
  input  logic                      cyc_write,
  input  logic                      cyc_long,
  input  logic                      cyc_after,
  output logic                      hit
);
  import bbrk_pkg::*;

  // Masked equality: a mask bit of 1 makes the bit don't-care
  function automatic logic addr_eq(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] r,
                                   input logic [ADDR_W-1:0] m);
    addr_eq = ((a ^ r) & ~m) == '0;
  endfunction

  function automatic logic data_eq(input logic [DATA_W-1:0] d,
                                   input logic [DATA_W-1:0] r,
                                   input logic [DATA_W-1:0] m);
    data_eq = ((d ^ r) & ~m) == '0;
  endfunction

  logic eff_write, addr_ok, type_ok, dir_ok, size_ok, time_ok, asid_ok, data_ok;

  always_comb begin
    eff_write = cyc_write & ~cyc_fetch;
    addr_ok   = addr_eq(cyc_addr, ref_addr, addr_mask);
    type_ok   = sel_ok(cond[C_TYPE_LO +: 2], ~cyc_fetch);
    dir_ok    = sel_ok(cond[C_DIR_LO +: 2], eff_write);
    size_ok   = sel_ok(cond[C_SIZE_LO +: 2], cyc_long);
    time_ok   = ~cyc_fetch | (cond[C_AFTER] == cyc_after);
    asid_ok   = ~cond[C_ASID_EN] | (cyc_asid == cond[ASID_W-1:0]);
    data_ok   = ~data_en | data_eq(cyc_data, ref_data, data_mask);
    hit = en & cyc_valid & addr_ok & type_ok & dir_ok & size_ok
        & time_ok & asid_ok & data_ok;
  end

  // R2: a write-only channel never matches a fetch
  p_fetch_not_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_fetch && cond[C_DIR_LO +: 2] == SEL_HIGH) |-> !hit);

  // R10: a disabled channel stays silent
  p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hit);

endmodule

// File: rtl/bbrk_seq.sv
module bbrk_seq #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode,
  input  logic             cnt_en,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic             ctrl_wr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             armed,
  output logic [CNT_W-1:0] cnt_left,
  output logic             brk_req,
  output logic [1:0]       brk_src
);

  // Saturating decrement of the execution counter
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    cnt_step = (c == '0) ? '0 : c - 1'b1;
  endfunction

  // Counter at or below one lets the match through
  function automatic logic cnt_due(input logic [CNT_W-1:0] c);
    cnt_due = (c <= CNT_W'(1));
  endfunction

  logic b_cand, fire_a, fire_b;

  always_comb begin
    b_cand = hit_b & (~seq_mode | armed);
    fire_b = b_cand & (~cnt_en | cnt_due(cnt_left));
    fire_a = hit_a & ~seq_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt_left <= '0;
      brk_req  <= 1'b0;
      brk_src  <= 2'b00;
    end else begin
      if (ctrl_wr || fire_b)     armed <= 1'b0;
      else if (seq_mode && hit_a) armed <= 1'b1;

      if (cnt_wr)                cnt_left <= cnt_wdata;
      else if (cnt_en && b_cand) cnt_left <= cnt_step(cnt_left);

      brk_src <= {fire_b, fire_a};
      brk_req <= fire_a | fire_b;
    end
  end

  // R6: an independent A match fires on the next cycle
  p_a_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && hit_a) |=> (brk_req && brk_src[0]));

  // R7: nothing fires in sequential mode until armed
  p_unarmed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed) |=> !brk_req);

  // R7: firing disarms the sequence
  p_fire_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && armed && hit_b && !cnt_en) |=> !armed);

  // R8: matches are absorbed while more than one execution remains
  p_count_absorb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_left > CNT_W'(1)) |=> !brk_src[1]);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [ASID_W-1:0] cyc_asid,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic              cyc_fetch,
  input  logic              cyc_write,
  input  logic              cyc_long,
  input  logic              cyc_after,
  output logic              brk_req,
  output logic [1:0]        brk_src
);
  import bbrk_pkg::*;

  localparam int NCH = 2;
  localparam int RW  = 32;

  logic [ADDR_W-1:0] addr_q [NCH];
  logic [ADDR_W-1:0] amask_q[NCH];
  logic [COND_W-1:0] cond_q [NCH];
  logic [DATA_W-1:0] dref_q, dmask_q;
  logic [NCH-1:0]    en_q, flag_q, hit;
  logic              seq_q, cnt_en_q, data_en_q;
  logic              ctrl_wr, cnt_wr, armed;
  logic [CNT_W-1:0]  cnt_left;

  assign ctrl_wr = reg_wr && reg_idx == IDX_CTRL;
  assign cnt_wr  = reg_wr && reg_idx == IDX_COUNT;

  // Per-channel register indices follow a stride of three
  function automatic logic [3:0] base_idx(input int ch);
    base_idx = 4'(ch * 3);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[c]  <= '0;
        amask_q[c] <= '0;
        cond_q[c]  <= '0;
      end else if (reg_wr) begin
        if (reg_idx == base_idx(c))      addr_q[c]  <= reg_wdata[ADDR_W-1:0];
        if (reg_idx == base_idx(c) + 1)  amask_q[c] <= reg_wdata[ADDR_W-1:0];
        if (reg_idx == base_idx(c) + 2)  cond_q[c]  <= reg_wdata[COND_W-1:0];
      end
    end

    // Only channel B carries the data comparator
    bbrk_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q[c]),
      .ref_addr  (addr_q[c]),
      .addr_mask (amask_q[c]),
      .cond      (cond_q[c]),
      .data_en   ((c == 1) ? data_en_q : 1'b0),
      .ref_data  (dref_q),
      .data_mask (dmask_q),
      .cyc_valid (cyc_valid),
      .cyc_addr  (cyc_addr),
      .cyc_asid  (cyc_asid),
      .cyc_data  (cyc_data),
      .cyc_fetch (cyc_fetch),
      .cyc_write (cyc_write),
      .cyc_long  (cyc_long),
      .cyc_after (cyc_after),
      .hit       (hit[c])
    );

    // Sticky flag: write 0 clears, a match in the same cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[c] <= 1'b0;
      else if (hit[c])   flag_q[c] <= 1'b1;
      else if (ctrl_wr)  flag_q[c] <= flag_q[c] & reg_wdata[K_FLAG_A + c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dref_q    <= '0;
      dmask_q   <= '0;
      en_q      <= '0;
      seq_q     <= 1'b0;
      cnt_en_q  <= 1'b0;
      data_en_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_idx == IDX_DATA_B)  dref_q  <= reg_wdata[DATA_W-1:0];
      if (reg_idx == IDX_DMASK_B) dmask_q <= reg_wdata[DATA_W-1:0];
      if (ctrl_wr) begin
        en_q      <= {reg_wdata[K_EN_B], reg_wdata[K_EN_A]};
        seq_q     <= reg_wdata[K_SEQ];
        cnt_en_q  <= reg_wdata[K_CNT];
        data_en_q <= reg_wdata[K_DATA];
      end
    end
  end

  bbrk_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_mode  (seq_q),
    .cnt_en    (cnt_en_q),
    .hit_a     (hit[0]),
    .hit_b     (hit[1]),
    .ctrl_wr   (ctrl_wr),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .armed     (armed),
    .cnt_left  (cnt_left),
    .brk_req   (brk_req),
    .brk_src   (brk_src)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_ADDR_A:  reg_rdata = RW'(addr_q[0]);
      IDX_MASK_A:  reg_rdata = RW'(amask_q[0]);
      IDX_COND_A:  reg_rdata = RW'(cond_q[0]);
      IDX_ADDR_B:  reg_rdata = RW'(addr_q[1]);
      IDX_MASK_B:  reg_rdata = RW'(amask_q[1]);
      IDX_COND_B:  reg_rdata = RW'(cond_q[1]);
      IDX_DATA_B:  reg_rdata = RW'(dref_q);
      IDX_DMASK_B: reg_rdata = RW'(dmask_q);
      IDX_CTRL: begin
        reg_rdata[K_EN_A]   = en_q[0];
        reg_rdata[K_EN_B]   = en_q[1];
        reg_rdata[K_SEQ]    = seq_q;
        reg_rdata[K_CNT]    = cnt_en_q;
        reg_rdata[K_DATA]   = data_en_q;
        reg_rdata[K_FLAG_A] = flag_q[0];
        reg_rdata[K_FLAG_B] = flag_q[1];
      end
      IDX_COUNT:   reg_rdata = RW'(cnt_left);
      default:     reg_rdata = '0;
    endcase
  end

  // R9: a set flag survives until a CTRL write
  p_flag_a_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !ctrl_wr) |=> flag_q[0]);
  p_flag_b_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !ctrl_wr) |=> flag_q[1]);

  // R7: a CTRL write drops the armed state
  p_ctrl_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !armed);

endmodule

// File: tb/bus_break_unit_tb.sv
`timescale 1ns/100ps
module bus_break_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [7:0]  cyc_asid = '0;
  logic [31:0] cyc_data = '0;
  logic        cyc_fetch = 1'b0, cyc_write = 1'b0, cyc_long = 1'b0, cyc_after = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_src;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bus_break_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_asid(cyc_asid), .cyc_data(cyc_data),
    .cyc_fetch(cyc_fetch), .cyc_write(cyc_write), .cyc_long(cyc_long),
    .cyc_after(cyc_after), .brk_req(brk_req), .brk_src(brk_src)
  );

  // Condition word builder: type 1 fetch / 2 data, dir 1 read / 2 write,
  // size 1 word / 2 long
  function automatic logic [31:0] cw(input int ty, input int dir, input int sz,
                                     input bit after, input bit asid_en,
                                     input logic [7:0] asid);
    cw = 32'(asid) | (32'(asid_en) << 8) | (32'(ty) << 9) | (32'(dir) << 11)
       | (32'(sz) << 13) | (32'(after) << 15);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  // Presents one cycle; returns at the negedge where the break is visible
  task automatic cyc(input logic [31:0] a, input logic [7:0] id,
                     input logic [31:0] d, input bit f, input bit w,
                     input bit l, input bit af);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_addr = a; cyc_asid = id; cyc_data = d;
    cyc_fetch = f; cyc_write = w; cyc_long = l; cyc_after = af;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10", {31'b0, brk_req}, 32'd0, "brk_req after reset");
    rd(4'd8, v);  check("R10", v, 32'd0, "CTRL after reset");
    rd(4'd0, v);  check("R10", v, 32'd0, "ADDR_A after reset");
    rd(4'd9, v);  check("R10", v, 32'd0, "COUNT after reset");
    cyc(32'h0, 8'h0, 32'h0, 0, 0, 0, 0);
    check("R10", {30'b0, brk_src}, 32'd0, "disabled channels silent");
    rd(4'd8, v);  check("R10", v, 32'd0, "no flag while disabled");
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, v); check("R11", v, 32'hDEAD_BEEF, "ADDR_A");
    wr(4'd7, 32'h0F0F_00FF); rd(4'd7, v); check("R11", v, 32'h0F0F_00FF, "DMASK_B");
    wr(4'd7, 32'h0);
  endtask

  task automatic t_addr();
    wr(4'd0, 32'h500); wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd8, 32'h1);
    cyc(32'h500, 0, 0, 0, 0, 1, 0); check("R1", {30'b0, brk_src}, 32'd1, "exact hit");
    cyc(32'h501, 0, 0, 0, 0, 1, 0); check("R1", {30'b0, brk_src}, 32'd0, "one-bit miss");
    wr(4'd1, 32'hF);
    cyc(32'h50C, 0, 0, 0, 0, 1, 0); check("R1", {30'b0, brk_src}, 32'd1, "masked hit");
    cyc(32'h510, 0, 0, 0, 0, 1, 0); check("R1", {30'b0, brk_src}, 32'd0, "outside mask");
    wr(4'd1, 32'h0);
  endtask

  task automatic t_attr();
    wr(4'd0, 32'h1000); wr(4'd2, cw(1, 2, 0, 0, 0, 0));
    cyc(32'h1000, 0, 0, 1, 1, 1, 0); check("R2", {31'b0, brk_req}, 32'd0, "fetch never write");
    wr(4'd2, cw(2, 2, 2, 0, 0, 0));
    cyc(32'h1000, 0, 0, 0, 1, 1, 0); check("R2", {31'b0, brk_req}, 32'd1, "data write long");
    cyc(32'h1000, 0, 0, 0, 1, 0, 0); check("R2", {31'b0, brk_req}, 32'd0, "size word rejected");
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R2", {31'b0, brk_req}, 32'd0, "read rejected");
  endtask

  task automatic t_timing();
    wr(4'd2, cw(1, 1, 0, 0, 0, 0));
    cyc(32'h1000, 0, 0, 1, 0, 1, 1); check("R3", {31'b0, brk_req}, 32'd0, "after rejected");
    cyc(32'h1000, 0, 0, 1, 0, 1, 0); check("R3", {31'b0, brk_req}, 32'd1, "before fires");
    wr(4'd2, cw(0, 0, 0, 1, 0, 0));
    cyc(32'h1000, 0, 0, 0, 0, 0, 0); check("R3", {31'b0, brk_req}, 32'd1, "data ignores timing");
  endtask

  task automatic t_asid();
    wr(4'd2, cw(0, 0, 0, 0, 1, 8'h80));
    cyc(32'h1000, 8'h70, 0, 0, 0, 0, 0); check("R4", {31'b0, brk_req}, 32'd0, "asid mismatch");
    cyc(32'h1000, 8'h80, 0, 0, 0, 0, 0); check("R4", {31'b0, brk_req}, 32'd1, "asid match");
    wr(4'd2, cw(0, 0, 0, 0, 0, 8'h80));
    cyc(32'h1000, 8'h70, 0, 0, 0, 0, 0); check("R4", {31'b0, brk_req}, 32'd1, "asid ignored");
  endtask

  task automatic t_data();
    wr(4'd3, 32'h2000); wr(4'd4, 32'h0); wr(4'd5, cw(2, 0, 0, 0, 0, 0));
    wr(4'd6, 32'h1234); wr(4'd7, 32'h00FF); wr(4'd8, 32'h12);
    cyc(32'h2000, 0, 32'h12AA, 0, 1, 1, 0); check("R5", {30'b0, brk_src}, 32'd2, "masked data hit");
    cyc(32'h2000, 0, 32'h1334, 0, 1, 1, 0); check("R5", {30'b0, brk_src}, 32'd0, "data miss");
    wr(4'd8, 32'h2);
    cyc(32'h2000, 0, 32'h9999, 0, 1, 1, 0); check("R5", {30'b0, brk_src}, 32'd2, "data ignored");
  endtask

  task automatic t_indep();
    wr(4'd0, 32'h3000); wr(4'd2, 32'h0); wr(4'd3, 32'h3000); wr(4'd5, 32'h0);
    wr(4'd8, 32'h3);
    cyc(32'h3000, 0, 0, 0, 0, 1, 0); check("R6", {30'b0, brk_src}, 32'd3, "both channels");
    check("R6", {31'b0, brk_req}, 32'd1, "request raised");
    @(negedge clk); check("R6", {31'b0, brk_req}, 32'd0, "single pulse");
  endtask

  task automatic t_seq();
    wr(4'd0, 32'h500); wr(4'd3, 32'h1000); wr(4'd8, 32'h7);
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R7", {31'b0, brk_req}, 32'd0, "B alone");
    cyc(32'h500, 0, 0, 0, 0, 1, 0);  check("R7", {31'b0, brk_req}, 32'd0, "A alone silent");
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R7", {30'b0, brk_src}, 32'd2, "A then B fires");
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R7", {31'b0, brk_req}, 32'd0, "disarmed after fire");
    cyc(32'h500, 0, 0, 0, 0, 1, 0);
    wr(4'd8, 32'h7);
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R7", {31'b0, brk_req}, 32'd0, "CTRL write disarms");
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(4'd8, 32'hA); wr(4'd9, 32'd5);
    for (int i = 0; i < 4; i++) begin
      cyc(32'h1000, 0, 0, 0, 0, 1, 0);
      check("R8", {31'b0, brk_req}, 32'd0, "absorbed match");
    end
    rd(4'd9, v); check("R8", v, 32'd1, "remaining count");
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R8", {30'b0, brk_src}, 32'd2, "fifth fires");
    rd(4'd9, v); check("R8", v, 32'd0, "count exhausted");
    cyc(32'h1000, 0, 0, 0, 0, 1, 0); check("R8", {31'b0, brk_req}, 32'd1, "fires at zero");
  endtask

  task automatic t_flags();
    logic [31:0] v;
    rd(4'd8, v); check("R9", v & 32'h300, 32'h200, "B flag set, A clear");
    wr(4'd8, 32'h20A); rd(4'd8, v); check("R9", v & 32'h200, 32'h200, "write 1 keeps");
    wr(4'd8, 32'h00A); rd(4'd8, v); check("R9", v & 32'h200, 32'h0, "write 0 clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_addr();
    t_attr();
    t_timing();
    t_asid();
    t_data();
    t_indep();
    wr(4'd8, 32'h0);
    t_seq();
    t_count();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule